// File: doc/BRIEF.md
# Write-Invalidate Bus Tenure Controller

This block controls bus ownership for a bus master that writes whole cache lines using the Write-and-Invalidate command. A data mover starts a job and gives the first command choice. The controller then raises the bus request and walks through the address phase and the data phase. It decides when a tenure must end and which command the next tenure uses: Write-and-Invalidate or plain Memory Write.

There are three ways a tenure ends early:

- **Latency timeout.** The latency timer is honoured only at a cache-line boundary while Write-and-Invalidate is in use. The controller remembers the timeout and keeps bursting until a completed beat closes a line.
- **Target retry.** Halt with no ready moves no data. The command is kept for the next tenure.
- **Target disconnect.** Halt with ready completes the beat. Write-and-Invalidate survives only if the resume address is line aligned.

After any early end, the request is held low for a fixed gap and then raised again at once. When the last beat completes, the job finishes and the controller returns to idle.

Top module: `wi_tenure_ctrl`

## Requirements
- R1: After reset, bus_req, bus_yield, job_done and use_wai are all 0.
- R2: A job_start pulse in idle loads use_wai from job_wai and raises bus_req on the next cycle. bus_req stays high without grant until bus_grant is seen, after which one address cycle and then data cycles follow.
- R3: With use_wai=1, a lat_expired pulse in the address or data phase is remembered. The tenure ends only after a completed beat (tgt_ready=1, tgt_halt=0) that has line_boundary=1. For a transfer starting line-aligned with 4-beat lines and a ready target, an expiry at beat k ends the tenure after beat 4*(k/4+1)-1. use_wai is unchanged.
- R4: With use_wai=0, a latency expiry ends the tenure after the first completed beat at or after the expiry.
- R5: A data cycle with tgt_ready=0 and tgt_halt=0 is a wait state. It never ends the tenure, even with line_boundary=1 and a pending expiry.
- R6: A retry (tgt_halt=1, tgt_ready=0 in a data cycle) ends the tenure on the next cycle and leaves use_wai unchanged.
- R7: A disconnect (tgt_halt=1, tgt_ready=1 in a data cycle) ends the tenure. The new use_wai equals the old use_wai AND addr_aligned.
- R8: After an early end, bus_yield is 1 and bus_req is 0 for exactly GAP_CYCLES cycles. On the cycle after bus_yield falls, bus_req is 1.
- R9: A completed beat with data_left=0 gives a one-cycle job_done with bus_req=0. The controller then idles with bus_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_start | input | 1 | Start a write job (accepted in idle) |
| job_wai | input | 1 | First tenure uses Write-and-Invalidate |
| bus_grant | input | 1 | Arbiter grant |
| lat_expired | input | 1 | Latency timer expiry |
| tgt_halt | input | 1 | Target asks to stop the transaction |
| tgt_ready | input | 1 | Target accepts the current data beat |
| line_boundary | input | 1 | Current beat is the last of a cache line |
| addr_aligned | input | 1 | Resume address is cache-line aligned |
| data_left | input | 1 | Data remains after the current beat |
| bus_req | output | 1 | Bus request |
| bus_yield | output | 1 | Ownership given up mid-job, re-request pending |
| use_wai | output | 1 | Command for the current/next tenure: 1 Write-and-Invalidate, 0 Memory Write |
| job_done | output | 1 | One-cycle pulse when the last beat completes |

## Verification
The bench sweeps the latency expiry across every beat of two cache lines under both commands. A design that released at once, or lost a timeout that arrived mid-line, would end Write-and-Invalidate tenures off a line boundary. Wait states that coincide with the boundary flag are driven to catch a design that counted boundaries without a completed beat. Retry and disconnect are swept over both commands and both alignment values: a design that confused the two would drop Write-and-Invalidate after a retry or keep it on a misaligned resume. Gap length and job completion are measured to catch a request that was never dropped or that stayed up after the last beat.

// File: rtl/wi_tenure_pkg.sv
// Shared types for the write-invalidate tenure controller.
package wi_tenure_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_RELEASE,
        ST_DONE
    } tenure_st_t;
endpackage

// File: rtl/wi_lat_defer.sv
// Latency expiry memory.
// Holds a latency timeout seen during a tenure until the tenure ends.
// Assumes lat_expired may be a single-cycle pulse.
module wi_lat_defer (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tenure,
    input  logic lat_expired,
    output logic lat_seen
);
    logic lat_pend;

    // Remember an expiry until the tenure closes.
    always_ff @(posedge clk) begin
        if (!rst_n)           lat_pend <= 1'b0;
        else if (!in_tenure)  lat_pend <= 1'b0;
        else if (lat_expired) lat_pend <= 1'b1;
    end

    // Expiry visible in the same cycle it arrives.
    always_comb lat_seen = lat_pend | (in_tenure & lat_expired);

    assert_lat_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tenure && lat_expired) |=> (!in_tenure || lat_seen));
endmodule

// File: rtl/wi_cmd_sel.sv
// Command selector.
// Keeps the command choice for the current and next tenure.
// Assumes load and discon are never high together.
module wi_cmd_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_wai,
    input  logic discon,
    input  logic addr_aligned,
    output logic use_wai
);
    // Load on job start; downgrade on a misaligned disconnect.
    always_ff @(posedge clk) begin
        if (!rst_n)      use_wai <= 1'b0;
        else if (load)   use_wai <= load_wai;
        else if (discon) use_wai <= use_wai & addr_aligned;
    end

    assert_discon_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (discon && addr_aligned) |=> $stable(use_wai));
endmodule

// File: rtl/wi_tenure_fsm.sv
// Tenure sequencer.
// Walks request, address and data phases and decides when a tenure ends.
// Assumes cmd_wai is stable during a data phase.
// GAP_CYCLES sets how long the request stays low between tenures.
module wi_tenure_fsm
    import wi_tenure_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic job_start,
    input  logic bus_grant,
    input  logic tgt_halt,
    input  logic tgt_ready,
    input  logic line_boundary,
    input  logic data_left,
    input  logic cmd_wai,
    input  logic lat_seen,
    output logic in_tenure,
    output logic in_data,
    output logic load,
    output logic retry,
    output logic discon,
    output logic bus_req,
    output logic bus_yield,
    output logic job_done
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    tenure_st_t st, nxt;
    logic [GW-1:0] gap_cnt;
    logic beat, last_beat, lat_rel;

    // Decode target responses within the data phase.
    always_comb begin
        in_data   = (st == ST_DATA);
        beat      = in_data & tgt_ready & ~tgt_halt;
        retry     = in_data & tgt_halt & ~tgt_ready;
        discon    = in_data & tgt_halt & tgt_ready;
        last_beat = beat & ~data_left;
        lat_rel   = beat & data_left & lat_seen & (cmd_wai ? line_boundary : 1'b1);
    end

    // Next-state selection.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:    if (job_start) nxt = ST_REQ;
            ST_REQ:     if (bus_grant) nxt = ST_ADDR;
            ST_ADDR:    nxt = ST_DATA;
            ST_DATA: begin
                if (retry || discon || lat_rel) nxt = ST_RELEASE;
                else if (last_beat)             nxt = ST_DONE;
            end
            ST_RELEASE: if (gap_cnt == GAP_LAST) nxt = ST_REQ;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Count cycles spent with the request dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_cnt <= '0;
        else if (st == ST_RELEASE)  gap_cnt <= gap_cnt + 1'b1;
        else                        gap_cnt <= '0;
    end

    // Output decode.
    always_comb begin
        bus_req   = (st == ST_REQ) || (st == ST_ADDR) || (st == ST_DATA);
        bus_yield = (st == ST_RELEASE);
        job_done  = (st == ST_DONE);
        in_tenure = (st == ST_ADDR) || (st == ST_DATA);
        load      = (st == ST_IDLE) && job_start;
    end

    assert_retry_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> bus_yield);
    assert_rerequest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_yield) |-> bus_req);
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !tgt_ready && !tgt_halt) |=> in_data);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> (!bus_req && !job_done));
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !in_tenure && !bus_grant) |=> bus_req);
endmodule

// File: rtl/wi_tenure_ctrl.sv
// Write-invalidate bus tenure controller (top).
// Combines the sequencer, latency memory and command selector.
// Assumes the data mover supplies line_boundary, addr_aligned and data_left
// for the current beat.
module wi_tenure_ctrl #(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic job_start,
    input  logic job_wai,
    input  logic bus_grant,
    input  logic lat_expired,
    input  logic tgt_halt,
    input  logic tgt_ready,
    input  logic line_boundary,
    input  logic addr_aligned,
    input  logic data_left,
    output logic bus_req,
    output logic bus_yield,
    output logic use_wai,
    output logic job_done
);
    logic in_tenure, in_data, load, retry, discon, lat_seen;

    wi_tenure_fsm #(.GAP_CYCLES(GAP_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .bus_grant(bus_grant),
        .tgt_halt(tgt_halt), .tgt_ready(tgt_ready), .line_boundary(line_boundary),
        .data_left(data_left), .cmd_wai(use_wai), .lat_seen(lat_seen),
        .in_tenure(in_tenure), .in_data(in_data), .load(load), .retry(retry),
        .discon(discon), .bus_req(bus_req), .bus_yield(bus_yield), .job_done(job_done)
    );

    wi_lat_defer lat_i (
        .clk(clk), .rst_n(rst_n), .in_tenure(in_tenure),
        .lat_expired(lat_expired), .lat_seen(lat_seen)
    );

    wi_cmd_sel cmd_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_wai(job_wai),
        .discon(discon), .addr_aligned(addr_aligned), .use_wai(use_wai)
    );

    assert_retry_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> $stable(use_wai));
    assert_discon_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (discon && !addr_aligned) |=> !use_wai);
    assert_wai_midline_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && use_wai && tgt_ready && !tgt_halt && data_left && !line_boundary)
        |=> !bus_yield);
endmodule

// File: tb/wi_tenure_ctrl_tb.sv
`timescale 1ns/1ps
module wi_tenure_ctrl_tb_top;
    localparam int GAP  = 2;
    localparam int LINE = 4;

    logic clk = 1'b0;
    logic rst_n, job_start, job_wai, bus_grant, lat_expired;
    logic tgt_halt, tgt_ready, line_boundary, addr_aligned, data_left;
    logic bus_req, bus_yield, use_wai, job_done;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wi_tenure_ctrl #(.GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_wai(job_wai),
        .bus_grant(bus_grant), .lat_expired(lat_expired), .tgt_halt(tgt_halt),
        .tgt_ready(tgt_ready), .line_boundary(line_boundary),
        .addr_aligned(addr_aligned), .data_left(data_left),
        .bus_req(bus_req), .bus_yield(bus_yield), .use_wai(use_wai),
        .job_done(job_done)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        job_start = 0; job_wai = 0; bus_grant = 0; lat_expired = 0;
        tgt_halt = 0; tgt_ready = 0; line_boundary = 0; addr_aligned = 0;
        data_left = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        quiet();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Ends at a negedge with the controller in the data phase.
    task automatic open_tenure(bit wai);
        do_reset();
        job_start = 1; job_wai = wai;
        @(negedge clk);
        job_start = 0; bus_grant = 1;
        @(negedge clk);
        bus_grant = 0;
        @(negedge clk);
    endtask

    // Ready target; returns the beat after which the tenure ended.
    task automatic run_beats(int k, output int rel);
        rel = -1;
        for (int b = 0; b < 40; b++) begin
            tgt_ready = 1;
            line_boundary = ((b + 1) % LINE == 0);
            lat_expired = (b == k);
            @(negedge clk);
            if (bus_yield) begin
                rel = b;
                break;
            end
        end
        quiet();
    endtask

    initial begin
        int rel, cnt;
        rst_n = 0;
        quiet();

        // R1 reset state
        do_reset();
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 bus_yield", int'(bus_yield), 0);
        chk("R1 job_done", int'(job_done), 0);
        chk("R1 use_wai", int'(use_wai), 0);

        // R2 request raised and held without grant
        job_start = 1; job_wai = 1;
        @(negedge clk);
        job_start = 0;
        chk("R2 use_wai loaded", int'(use_wai), 1);
        for (int i = 0; i < 5; i++) begin
            chk("R2 bus_req held", int'(bus_req), 1);
            @(negedge clk);
        end

        // R3/R4 latency expiry sweep over two lines, both commands
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 2 * LINE; k++) begin
                open_tenure(w[0]);
                run_beats(k, rel);
                if (w == 1) begin
                    chk("R3 release beat", rel, (k / LINE + 1) * LINE - 1);
                    chk("R3 command kept", int'(use_wai), 1);
                end else begin
                    chk("R4 release beat", rel, k);
                end
            end
        end

        // R5 wait states at a boundary do not release
        open_tenure(1);
        tgt_ready = 1; lat_expired = 1;
        @(negedge clk);
        lat_expired = 0; tgt_ready = 0; line_boundary = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 wait no release", int'(bus_yield), 0);
            chk("R5 wait keeps req", int'(bus_req), 1);
        end
        tgt_ready = 1;
        @(negedge clk);
        chk("R5 release after boundary beat", int'(bus_yield), 1);
        quiet();

        // R6/R8 retry after j beats, then gap length and re-request
        for (int j = 0; j < 3; j++) begin
            open_tenure(1);
            for (int b = 0; b < j; b++) begin
                tgt_ready = 1;
                @(negedge clk);
            end
            tgt_ready = 0; tgt_halt = 1;
            @(negedge clk);
            quiet();
            chk("R6 retry releases", int'(bus_yield), 1);
            chk("R6 retry keeps wai", int'(use_wai), 1);
            cnt = 0;
            for (int t = 0; t < 20 && bus_yield; t++) begin
                chk("R8 req low in gap", int'(bus_req), 0);
                cnt++;
                @(negedge clk);
            end
            chk("R8 gap length", cnt, GAP);
            chk("R8 re-request", int'(bus_req), 1);
        end

        // R7 disconnect over command and alignment
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 2; a++) begin
                open_tenure(w[0]);
                tgt_ready = 1;
                @(negedge clk);
                tgt_halt = 1; addr_aligned = a[0];
                @(negedge clk);
                quiet();
                chk("R7 disconnect releases", int'(bus_yield), 1);
                chk("R7 next command", int'(use_wai), w & a);
            end
        end

        // R9 completion
        open_tenure(0);
        tgt_ready = 1;
        repeat (2) @(negedge clk);
        data_left = 0;
        @(negedge clk);
        quiet();
        chk("R9 done pulse", int'(job_done), 1);
        chk("R9 req low at done", int'(bus_req), 0);
        @(negedge clk);
        chk("R9 done single", int'(job_done), 0);
        for (int i = 0; i < 3; i++) begin
            chk("R9 idle no req", int'(bus_req), 0);
            @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule